// File: doc/BRIEF.md
# Region Wait-State Generator

This block sits on the request side of a CPU memory bus and decides how long each access must wait. The CPU presents a start pulse together with a precomputed region code, a read/write flag and a flash page number. The block turns these into a wait count for that region and direction, and holds a single `stall` line high for that many cycles. Peripheral regions that allow it can lengthen the access further through a ready input. Back-to-back writes to the first peripheral frame get one extra cycle.

Flash timing depends on access history. An access to the same flash page as the flash access just before it uses the paged count. Any other flash access uses the random count. Three 4-bit wait fields (OTP, flash paged, flash random) are loaded through a small write port. A password window in flash always costs a fixed 16 cycles. The memories, arbitration between masters and flash programming are outside this block.

Top module: `bus_wait_gen`

## Requirements
- R1: Region codes are 0 scratch RAM, 1 boot ROM, 2 peripheral frame A, 3 peripheral frame B, 4 peripheral frame C, 5 OTP, 6 flash, 7 flash password window. Codes 0 and 1 complete reads and writes with zero stall cycles.
- R2: Peripheral frames A, B and C give writes zero wait cycles and reads PER_RD_WAIT (default 2) wait cycles.
- R3: A write to frame A that is accepted in the first stall-free cycle after another frame-A write gets one extra wait cycle. An idle cycle or any other access in between removes the extra cycle.
- R4: For frames A and C, `periph_rdy` is sampled at the clock edge that ends the wait count, which is the accepting edge when the count is zero. Each low sample adds one stall cycle, and `stall` falls after the edge that samples it high. All other regions, frame B included, ignore `periph_rdy`.
- R5: An OTP access waits the OTP field value, and a field value of 0 is treated as 1.
- R6: A flash access uses the paged field when the previous accepted access was also a flash access to the same page. Otherwise, including the first flash access after reset, it uses the random field.
- R7: Both flash fields are used as programmed, zero included.
- R8: A password-window access always waits 16 cycles, whatever the flash fields hold.
- R9: A write with `cfg_we` high loads `cfg_wdata` into the field picked by `cfg_sel` (0 OTP, 1 flash paged, 2 flash random) at the clock edge. All fields reset to 15.
- R10: A start is accepted only in a cycle where `stall` is low. After the accepting edge, `stall` is high for exactly the computed number of cycles. A start pulsed while `stall` is high is dropped.
- R11: While `rst_n` is low, `stall` is low at once and the access history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start | input | 1 | Access start pulse |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_region | input | 3 | Region code of the access |
| acc_page | input | PAGE_W | Flash page number of the access |
| periph_rdy | input | 1 | Peripheral ready, honoured for frames A and C only |
| cfg_we | input | 1 | Wait-field write strobe |
| cfg_sel | input | 2 | Field select for the write |
| cfg_wdata | input | WS_W | Value written to the field |
| stall | output | 1 | High while the current access is waiting |

## Verification
The bench builds the block with 4-bit wait fields and a 4-bit flash page number; all other parameters keep their defaults. With 4-bit fields, the reset value of 15, a clamped zero, small OTP values and a zero flash count can all be reached with a handful of writes. The fixed 16-cycle password window then lies above every programmable value, which tests that the counter is wide enough for it. The small page width keeps page matches and misses easy to steer. Ready is held low for chosen edge counts so that the extension, and its absence on frame B, is seen cycle by cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef enum logic [2:0] {
    RG_SRAM   = 3'd0,
    RG_ROM    = 3'd1,
    RG_PERA   = 3'd2,
    RG_PERB   = 3'd3,
    RG_PERC   = 3'd4,
    RG_OTP    = 3'd5,
    RG_FLASH  = 3'd6,
    RG_KEYWIN = 3'd7
  } region_e;

  localparam int NUM_CFG = 3;
  localparam int CFG_OTP   = 0;
  localparam int CFG_FPAGE = 1;
  localparam int CFG_FRAND = 2;

endpackage

// File: rtl/wsg_cfg_regs.sv
module wsg_cfg_regs #(
  parameter int WS_W = 4,
  parameter int NREG = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [WS_W-1:0]        wr_data,
  output logic [NREG*WS_W-1:0]   fields
);

  for (genvar g = 0; g < NREG; g++) begin : g_field
    logic [WS_W-1:0] val_q;
    logic [WS_W-1:0] val_d;
    logic            hit;

    assign hit = wr_en && (wr_sel == 2'(g));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '1;
      else        val_q <= val_d;
    end

    assign fields[g*WS_W +: WS_W] = val_q;
  end

endmodule

// File: rtl/wsg_history.sv
module wsg_history
  import wsg_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              start,
  input  logic              stall,
  input  region_e           region,
  input  logic              we,
  input  logic [PAGE_W-1:0] page,
  output logic              b2b_write,
  output logic              same_page
);

  logic              pera_wr_q, pera_wr_d;
  logic              fl_vld_q, fl_vld_d;
  logic [PAGE_W-1:0] fl_page_q, fl_page_d;
  logic              idle;

  assign idle = !stall && !start;

  always_comb begin
    pera_wr_d = pera_wr_q;
    fl_vld_d  = fl_vld_q;
    fl_page_d = fl_page_q;
    if (accept) begin
      pera_wr_d = (region == RG_PERA) && we;
      fl_vld_d  = (region == RG_FLASH);
      fl_page_d = page;
    end else if (idle) begin
      pera_wr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pera_wr_q <= 1'b0;
      fl_vld_q  <= 1'b0;
      fl_page_q <= '0;
    end else begin
      pera_wr_q <= pera_wr_d;
      fl_vld_q  <= fl_vld_d;
      fl_page_q <= fl_page_d;
    end
  end

  assign b2b_write = pera_wr_q;
  assign same_page = fl_vld_q && (fl_page_q == page);

endmodule

// File: rtl/wsg_decode.sv
module wsg_decode
  import wsg_pkg::*;
#(
  parameter int WS_W        = 4,
  parameter int CNT_W       = 5,
  parameter int PER_RD_WAIT = 2,
  parameter int KEY_WAIT    = 16,
  parameter int OTP_MIN     = 1
) (
  input  region_e          region,
  input  logic             we,
  input  logic             b2b_write,
  input  logic             same_page,
  input  logic [WS_W-1:0]  otp_ws,
  input  logic [WS_W-1:0]  fpage_ws,
  input  logic [WS_W-1:0]  frand_ws,
  output logic [CNT_W-1:0] wait_n,
  output logic             ext_ok
);

  logic [CNT_W-1:0] per_wait;
  logic [CNT_W-1:0] otp_eff;

  always_comb begin
    per_wait = we ? '0 : CNT_W'(PER_RD_WAIT);
    otp_eff  = (otp_ws < WS_W'(OTP_MIN)) ? CNT_W'(OTP_MIN) : CNT_W'(otp_ws);
  end

  always_comb begin
    wait_n = '0;
    ext_ok = 1'b0;
    case (region)
      RG_SRAM, RG_ROM: wait_n = '0;
      RG_PERA: begin
        wait_n = per_wait + ((we && b2b_write) ? CNT_W'(1) : '0);
        ext_ok = 1'b1;
      end
      RG_PERB:   wait_n = per_wait;
      RG_PERC: begin
        wait_n = per_wait;
        ext_ok = 1'b1;
      end
      RG_OTP:    wait_n = otp_eff;
      RG_FLASH:  wait_n = same_page ? CNT_W'(fpage_ws) : CNT_W'(frand_ws);
      RG_KEYWIN: wait_n = CNT_W'(KEY_WAIT);
      default:   wait_n = '0;
    endcase
  end

endmodule

// File: rtl/wsg_counter.sv
module wsg_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_ext,
  input  logic             rdy,
  output logic             stall,
  output logic             hold
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ext_q, ext_d;
  logic             hold_q, hold_d;

  always_comb begin
    cnt_d  = cnt_q;
    ext_d  = ext_q;
    hold_d = hold_q;
    if (accept) begin
      cnt_d  = load_val;
      ext_d  = load_ext;
      hold_d = (load_val == '0) && load_ext && !rdy;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) hold_d = ext_q && !rdy;
    end else if (hold_q && rdy) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ext_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      hold_q <= hold_d;
    end
  end

  assign stall = (cnt_q != '0) || hold_q;
  assign hold  = hold_q;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import wsg_pkg::*;
#(
  parameter int WS_W        = 4,
  parameter int PAGE_W      = 8,
  parameter int PER_RD_WAIT = 2,
  parameter int KEY_WAIT    = 16,
  parameter int OTP_MIN     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_we,
  input  logic [2:0]        acc_region,
  input  logic [PAGE_W-1:0] acc_page,
  input  logic              periph_rdy,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WS_W-1:0]   cfg_wdata,
  output logic              stall
);

  localparam int FIELD_MAX = (1 << WS_W) - 1;
  localparam int MAX_A     = (KEY_WAIT > FIELD_MAX) ? KEY_WAIT : FIELD_MAX;
  localparam int MAX_WAIT  = (MAX_A > PER_RD_WAIT + 1) ? MAX_A : PER_RD_WAIT + 1;
  localparam int CNT_W     = $clog2(MAX_WAIT + 1);

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  region_e                 region;
  logic                    accept;
  logic                    stall_w;
  logic                    hold_w;
  logic                    b2b_write;
  logic                    same_page;
  logic [NUM_CFG*WS_W-1:0] fields;
  logic [CNT_W-1:0]        wait_n;
  logic                    ext_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign region = region_e'(acc_region);
  assign accept = acc_start && !stall_w;

  wsg_cfg_regs #(.WS_W(WS_W), .NREG(NUM_CFG)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .fields  (fields)
  );

  wsg_history #(.PAGE_W(PAGE_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .start     (acc_start),
    .stall     (stall_w),
    .region    (region),
    .we        (acc_we),
    .page      (acc_page),
    .b2b_write (b2b_write),
    .same_page (same_page)
  );

  wsg_decode #(
    .WS_W(WS_W), .CNT_W(CNT_W), .PER_RD_WAIT(PER_RD_WAIT),
    .KEY_WAIT(KEY_WAIT), .OTP_MIN(OTP_MIN)
  ) u_dec (
    .region    (region),
    .we        (acc_we),
    .b2b_write (b2b_write),
    .same_page (same_page),
    .otp_ws    (fields[CFG_OTP*WS_W +: WS_W]),
    .fpage_ws  (fields[CFG_FPAGE*WS_W +: WS_W]),
    .frand_ws  (fields[CFG_FRAND*WS_W +: WS_W]),
    .wait_n    (wait_n),
    .ext_ok    (ext_ok)
  );

  wsg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .load_val (wait_n),
    .load_ext (ext_ok),
    .rdy      (periph_rdy),
    .stall    (stall_w),
    .hold     (hold_w)
  );

  assign stall = stall_w;

endmodule

// File: rtl/bus_wait_gen_chk.sv
module bus_wait_gen_chk
  import wsg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       acc_start,
  input logic [2:0] acc_region,
  input logic       periph_rdy,
  input logic       stall,
  input logic       hold
);

  logic acc_ok;
  logic cur_perb_q;

  assign acc_ok = acc_start && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_perb_q <= 1'b0;
    else if (acc_ok) cur_perb_q <= (acc_region == RG_PERB);
  end

  AST_FAST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (acc_region == RG_SRAM || acc_region == RG_ROM) |=> !stall); // R1

  AST_PERB_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    cur_perb_q |-> !hold); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !periph_rdy |=> stall); // R4

  AST_OTP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (acc_region == RG_OTP) |=> stall); // R5

  AST_KEY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (acc_region == RG_KEYWIN) |=> stall); // R8

endmodule

bind bus_wait_gen bus_wait_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_start  (acc_start),
  .acc_region (acc_region),
  .periph_rdy (periph_rdy),
  .stall      (stall),
  .hold       (hold_w)
);

// File: tb/bus_wait_gen_tb.sv
module bus_wait_gen_tb;

  localparam int WS_W   = 4;
  localparam int PAGE_W = 4;
  localparam int NVEC   = 27;

  localparam logic [2:0] SR = 3'd0, RO = 3'd1, PA = 3'd2, PB = 3'd3,
                         PC = 3'd4, OT = 3'd5, FL = 3'd6, KW = 3'd7;

  // {gap[2], region[3], we, page[4], rdy_low[3], expected[5]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, SR, 1'b0, 4'd0, 3'd0, 5'd0},
    {2'd0, RO, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, PB, 1'b0, 4'd0, 3'd0, 5'd2},
    {2'd0, PB, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, PA, 1'b0, 4'd0, 3'd0, 5'd2},
    {2'd0, PA, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, PA, 1'b1, 4'd0, 3'd0, 5'd1},
    {2'd0, PA, 1'b1, 4'd0, 3'd0, 5'd1},
    {2'd1, PA, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, PC, 1'b0, 4'd0, 3'd0, 5'd2},
    {2'd0, PC, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, PC, 1'b1, 4'd0, 3'd0, 5'd0},
    {2'd0, OT, 1'b0, 4'd0, 3'd0, 5'd1},
    {2'd0, FL, 1'b0, 4'd3, 3'd0, 5'd5},
    {2'd0, FL, 1'b1, 4'd3, 3'd0, 5'd2},
    {2'd3, FL, 1'b0, 4'd3, 3'd0, 5'd2},
    {2'd0, FL, 1'b0, 4'd4, 3'd0, 5'd5},
    {2'd0, SR, 1'b0, 4'd0, 3'd0, 5'd0},
    {2'd0, FL, 1'b0, 4'd4, 3'd0, 5'd5},
    {2'd0, KW, 1'b0, 4'd4, 3'd0, 5'd16},
    {2'd0, FL, 1'b0, 4'd4, 3'd0, 5'd5},
    {2'd0, PB, 1'b0, 4'd0, 3'd3, 5'd2},
    {2'd0, PA, 1'b0, 4'd0, 3'd3, 5'd5},
    {2'd0, PC, 1'b1, 4'd0, 3'd2, 5'd2},
    {2'd0, PA, 1'b1, 4'd0, 3'd1, 5'd1},
    {2'd0, PA, 1'b1, 4'd0, 3'd0, 5'd1},
    {2'd0, SR, 1'b0, 4'd0, 3'd4, 5'd0}
  };

  logic              clk;
  logic              rst_n;
  logic              acc_start;
  logic              acc_we;
  logic [2:0]        acc_region;
  logic [PAGE_W-1:0] acc_page;
  logic              periph_rdy;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [WS_W-1:0]   cfg_wdata;
  logic              stall;

  int   n_chk;
  int   n_fail;
  bit   finished;
  logic [17:0] v;

  bus_wait_gen #(.WS_W(WS_W), .PAGE_W(PAGE_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_start  (acc_start),
    .acc_we     (acc_we),
    .acc_region (acc_region),
    .acc_page   (acc_page),
    .periph_rdy (periph_rdy),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .stall      (stall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [WS_W-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Called at a falling edge; returns there with stall low.
  task automatic run_acc(input logic [2:0] rg, input logic we, input logic [3:0] pg,
                         input int rl, input int exp, input string tag);
    int thresh;
    int j;
    int n;
    thresh = (rg == PA || rg == PC) ? exp : exp + rl;
    acc_region = rg; acc_we = we; acc_page = pg;
    acc_start  = 1'b1;
    periph_rdy = (0 >= thresh);
    @(negedge clk);
    acc_start  = 1'b0;
    j = 0; n = 0;
    periph_rdy = (1 >= thresh);
    while (stall && n < 64) begin
      n++;
      @(negedge clk);
      j++;
      periph_rdy = (j + 1 >= thresh);
    end
    periph_rdy = 1'b1;
    check(tag, n, exp);
  endtask

  function automatic string tag_of(input logic [2:0] rg, input logic we, input int rl);
    if (rg == SR || rg == RO) return "R1";
    if (rl != 0)              return "R4";
    if (rg == PA && we)       return "R3";
    if (rg == PA || rg == PB || rg == PC) return "R2";
    if (rg == OT)             return "R5";
    if (rg == FL)             return "R6";
    return "R8";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; acc_start = 1'b0; acc_we = 1'b0; acc_region = '0; acc_page = '0;
    periph_rdy = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R11 stall in reset", int'(stall), 0);
    rst_n = 1'b1;
    idle(4);
    check("R11 stall after reset", int'(stall), 0);

    // R9 reset values, R6 first flash access is random
    run_acc(FL, 1'b0, 4'd1, 0, 15, "R9 flash reset field");
    run_acc(FL, 1'b0, 4'd1, 0, 15, "R9 flash paged reset field");
    run_acc(OT, 1'b0, 4'd0, 0, 15, "R9 otp reset field");

    cfg_write(2'd0, 4'd0);
    cfg_write(2'd1, 4'd2);
    cfg_write(2'd2, 4'd5);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      idle(int'(v[17:16]));
      run_acc(v[15:13], v[12], v[11:8], int'(v[7:5]), int'(v[4:0]),
              tag_of(v[15:13], v[12], int'(v[7:5])));
    end

    // R7 zero paged count, nonzero random
    cfg_write(2'd1, 4'd0);
    cfg_write(2'd2, 4'd9);
    run_acc(FL, 1'b0, 4'd7, 0, 9, "R7 flash random 9");
    run_acc(FL, 1'b0, 4'd7, 0, 0, "R7 flash paged 0");
    run_acc(KW, 1'b1, 4'd7, 0, 16, "R8 key window fixed");
    cfg_write(2'd2, 4'd0);
    run_acc(FL, 1'b0, 4'd2, 0, 0, "R7 flash random 0");

    // R5 OTP values above the minimum
    cfg_write(2'd0, 4'd3);
    run_acc(OT, 1'b0, 4'd0, 0, 3, "R5 otp 3");
    cfg_write(2'd0, 4'd1);
    run_acc(OT, 1'b1, 4'd0, 0, 1, "R5 otp 1");

    // R10 start while stalled is dropped
    acc_region = KW; acc_we = 1'b0; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
    n = 0;
    while (stall && n < 64) begin
      n++;
      if (n == 4) begin acc_region = PB; acc_start = 1'b1; end
      else acc_start = 1'b0;
      @(negedge clk);
    end
    acc_start = 1'b0;
    check("R10 busy start dropped length", n, 16);
    @(negedge clk);
    check("R10 no queued access", int'(stall), 0);

    // R11 reset in mid access
    run_acc(SR, 1'b0, 4'd0, 0, 0, "R1 sram before reset");
    acc_region = KW; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
    idle(2);
    check("R10 stall during key access", int'(stall), 1);
    rst_n = 1'b0;
    #1;
    check("R11 stall drops on reset", int'(stall), 0);
    idle(2);
    rst_n = 1'b1;
    idle(4);
    run_acc(OT, 1'b0, 4'd0, 0, 15, "R9 otp field back to reset");
    run_acc(FL, 1'b0, 4'd7, 0, 15, "R11 flash history cleared");

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule